// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Engine

The engine copies frames arriving as a byte stream into buffers in system memory. Each buffer is described by an eight-word descriptor. Word 0 holds control: length in bits 15:0, last-segment flag in bit 29, first-segment flag in bit 30 and the ownership flag in bit 31. Word 1 holds the address of the next descriptor. Word 2 holds the buffer address. Word 4 receives the status, and the remaining words are unused. The engine uses a descriptor only while its ownership flag is 1. After a frame it writes the status word, then writes the control word with the stored length and the ownership flag cleared. It then raises an end-of-frame interrupt and moves on through the next pointer. Two descriptors that point at each other therefore form a ring.

Software sees two registers through a single write/read port. Register select 0 is the control/status register: start is bit 4, stop is bit 5, and the write-one-to-clear end-of-frame flag is bit 1. Reading bit 4 returns the running state. Register select 1 is the current-descriptor address, loaded by software before start. Memory is reached through a request/acknowledge master port that has 32-bit data and byte enables. Buffers and descriptors are word aligned.

Top module: `rxring_dma`

## Requirements
- R1: After reset in_ready, mem_req and irq are 0, and both registers read 0.
- R2: Writing 1 to bit 4 of register 0 while stopped starts a fetch at the address held in register 1, and bit 4 then reads 1. Writes to register 1 are ignored while running.
- R3: No byte is accepted from a descriptor whose word-0 bit 31 is 0. The engine keeps re-reading that descriptor and proceeds once the bit becomes 1.
- R4: Accepted byte i of a frame is stored at byte address (word 2) + i, little-endian within each 32-bit word.
- R5: Bytes beyond the length in word-0 bits 15:0 are dropped, and memory past that length is left untouched. A frame that ends exactly at the length is not treated as an overflow.
- R6: On completion, word 0 is rewritten with bits 15:0 holding the stored byte count, bit 31 cleared and bits 30:16 kept. Word 4 is written with bit 8 set only if there was no source error and no overflow, bit 9 set on overflow, and bit 10 set on a source error.
- R7: The status word (word 4) is written before the control word of the same descriptor.
- R8: The interrupt flag (irq, register 0 bit 1) rises after the control-word write is acknowledged. It stays set until 1 is written to bit 1.
- R9: After completing a descriptor, the engine continues at the address found in its word 1, and register 1 reads that address.
- R10: Writing 1 to bit 5 stops the engine at the next descriptor boundary, so a frame in progress still completes. Once stopped, in_ready and mem_req stay 0 and bit 4 reads 0.
- R11: mem_req stays high with a stable address until mem_ack. No byte is accepted while a memory access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control/status, 1 current descriptor |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_sel |
| irq | output | 1 | End-of-frame interrupt flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Byte address, word aligned |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed; read data valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_err | input | 1 | Source flagged the frame as bad |
| in_ready | output | 1 | Engine accepts a byte this cycle |

## Verification
Random-length frames of 1 to 64 bytes, some of them flagged bad, alternate between two linked descriptors. These frames separate correct byte-lane packing, partial trailing words, status bits and ring following. Directed frames of exactly the buffer length and longer than it separate the boundary from an overflow. A 10-byte buffer fed 13 bytes shows whether a partial word is written with the right byte enables only. A descriptor left with ownership cleared shows whether the engine stalls without accepting bytes and then resumes. A stop issued mid-frame shows that the frame still completes and the engine then goes quiet.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FCTL, S_FNXT, S_FBUF, S_RECV, S_WDATA, S_WSTAT, S_WCTL
  } rxd_state_e;

  localparam int DW         = 32;
  localparam int LW         = 16;
  localparam int OWN_BIT    = 31;
  localparam int OK_BIT     = 8;
  localparam int LENERR_BIT = 9;
  localparam int SRCERR_BIT = 10;
  localparam int RUN_BIT    = 4;
  localparam int EOF_BIT    = 1;
  localparam int OFF_NXT    = 4;
  localparam int OFF_BUF    = 8;
  localparam int OFF_STAT   = 16;
endpackage

// File: rtl/rxd_pack.sv
module rxd_pack #(
  parameter int LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 load,
  input  logic [$clog2(LANES)-1:0] lane,
  input  logic [7:0]           din,
  output logic [8*LANES-1:0]   word,
  output logic [LANES-1:0]     be
);
  logic [LANES-1:0] hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = load && (lane == g[$clog2(LANES)-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word <= '0;
      be   <= '0;
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (hit[k]) begin
          word[8*k +: 8] <= din;
          be[k]          <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxd_csr.sv
module rxd_csr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic          bit_eof,
  input  logic          bit_start,
  input  logic          bit_stop,
  input  logic          running,
  input  logic [AW-1:0] cur_addr,
  input  logic          frame_done,
  output logic          start_p,
  output logic          stop_p,
  output logic          cur_wr,
  output logic          irq,
  output logic [31:0]   reg_rdata
);
  import rxd_pkg::*;

  logic        ctl_wr;
  logic [31:0] stat_view;

  assign ctl_wr  = reg_wr && !reg_sel;
  assign start_p = ctl_wr && bit_start && !bit_stop;
  assign stop_p  = ctl_wr && bit_stop;
  assign cur_wr  = reg_wr && reg_sel;

  always_ff @(posedge clk) begin
    if (rst)
      irq <= 1'b0;
    else if (frame_done)
      irq <= 1'b1;
    else if (ctl_wr && bit_eof)
      irq <= 1'b0;
  end

  always_comb begin
    stat_view          = '0;
    stat_view[RUN_BIT] = running;
    stat_view[EOF_BIT] = irq;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else
      reg_rdata <= reg_sel ? 32'(cur_addr) : stat_view;
  end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic          cur_wr,
  input  logic [AW-1:0] cur_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          in_valid,
  input  logic          in_last,
  input  logic          in_err,
  output logic          in_ready,
  input  logic [31:0]   pk_word,
  input  logic [3:0]    pk_be,
  output logic          pk_clr,
  output logic          pk_load,
  output logic [1:0]    pk_lane,
  output logic          frame_done,
  output logic          running,
  output logic [AW-1:0] cur_addr
);
  import rxd_pkg::*;

  rxd_state_e    st;
  logic [AW-1:0] cur_q, nxt_q, wptr_q;
  logic [14:0]   ctl_q;
  logic [LW-1:0] blen_q, cnt_q;
  logic          ovf_q, err_q, last_q, stop_q;
  logic          take, keep, flush;
  logic [31:0]   stat_w;

  assign cur_addr = cur_q;
  assign running  = (st != S_IDLE);
  assign in_ready = (st == S_RECV);
  assign take     = in_valid && in_ready;
  assign keep     = cnt_q < blen_q;
  assign flush    = keep ? ((cnt_q[1:0] == 2'd3) || in_last) : (in_last && (pk_be != 4'd0));
  assign pk_load  = take && keep;
  assign pk_lane  = cnt_q[1:0];
  assign pk_clr   = (st == S_WDATA) && mem_ack;
  assign frame_done = (st == S_WCTL) && mem_ack;

  always_comb begin
    stat_w             = '0;
    stat_w[OK_BIT]     = !ovf_q && !err_q;
    stat_w[LENERR_BIT] = ovf_q;
    stat_w[SRCERR_BIT] = err_q;
  end

  always_comb begin
    mem_req   = st inside {S_FCTL, S_FNXT, S_FBUF, S_WDATA, S_WSTAT, S_WCTL};
    mem_we    = st inside {S_WDATA, S_WSTAT, S_WCTL};
    mem_be    = 4'hF;
    mem_wdata = '0;
    mem_addr  = cur_q;
    case (st)
      S_FNXT:  mem_addr = cur_q + AW'(OFF_NXT);
      S_FBUF:  mem_addr = cur_q + AW'(OFF_BUF);
      S_WSTAT: begin
        mem_addr  = cur_q + AW'(OFF_STAT);
        mem_wdata = stat_w;
      end
      S_WDATA: begin
        mem_addr  = wptr_q;
        mem_be    = pk_be;
        mem_wdata = pk_word;
      end
      S_WCTL:  mem_wdata = {1'b0, ctl_q, cnt_q};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cur_q  <= '0;
      nxt_q  <= '0;
      wptr_q <= '0;
      ctl_q  <= '0;
      blen_q <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
      last_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      if (stop_p) stop_q <= 1'b1;
      case (st)
        S_IDLE: begin
          stop_q <= 1'b0;
          if (cur_wr) cur_q <= cur_wdata;
          if (start_p) st <= S_FCTL;
        end
        S_FCTL: if (mem_ack) begin
          if (stop_q || stop_p) begin
            st <= S_IDLE;
          end else if (mem_rdata[OWN_BIT]) begin
            ctl_q  <= mem_rdata[30:16];
            blen_q <= mem_rdata[LW-1:0];
            st     <= S_FNXT;
          end
        end
        S_FNXT: if (mem_ack) begin
          nxt_q <= mem_rdata[AW-1:0];
          st    <= S_FBUF;
        end
        S_FBUF: if (mem_ack) begin
          wptr_q <= mem_rdata[AW-1:0];
          cnt_q  <= '0;
          ovf_q  <= 1'b0;
          err_q  <= 1'b0;
          last_q <= 1'b0;
          st     <= S_RECV;
        end
        S_RECV: if (take) begin
          err_q  <= err_q | in_err;
          last_q <= in_last;
          if (keep) cnt_q <= cnt_q + LW'(1);
          else      ovf_q <= 1'b1;
          if (flush)        st <= S_WDATA;
          else if (in_last) st <= S_WSTAT;
        end
        S_WDATA: if (mem_ack) begin
          wptr_q <= wptr_q + AW'(4);
          st     <= last_q ? S_WSTAT : S_RECV;
        end
        S_WSTAT: if (mem_ack) st <= S_WCTL;
        S_WCTL: if (mem_ack) begin
          cur_q <= nxt_q;
          st    <= (stop_q || stop_p) ? S_IDLE : S_FCTL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxring_dma.sv
module rxring_dma #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_err,
  output logic          in_ready
);
  logic          start_p, stop_p, cur_wr, frame_done, running;
  logic          pk_clr, pk_load;
  logic [1:0]    pk_lane;
  logic [31:0]   pk_word;
  logic [3:0]    pk_be;
  logic [AW-1:0] cur_addr;

  rxd_csr #(.AW(AW)) u_csr (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .bit_eof(reg_wdata[1]), .bit_start(reg_wdata[4]), .bit_stop(reg_wdata[5]),
    .running(running), .cur_addr(cur_addr), .frame_done(frame_done),
    .start_p(start_p), .stop_p(stop_p), .cur_wr(cur_wr),
    .irq(irq), .reg_rdata(reg_rdata)
  );

  rxd_pack #(.LANES(4)) u_pack (
    .clk(clk), .rst(rst), .clr(pk_clr), .load(pk_load), .lane(pk_lane),
    .din(in_data), .word(pk_word), .be(pk_be)
  );

  rxd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .start_p(start_p), .stop_p(stop_p),
    .cur_wr(cur_wr), .cur_wdata(reg_wdata[AW-1:0]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .in_valid(in_valid), .in_last(in_last), .in_err(in_err), .in_ready(in_ready),
    .pk_word(pk_word), .pk_be(pk_be), .pk_clr(pk_clr), .pk_load(pk_load),
    .pk_lane(pk_lane), .frame_done(frame_done), .running(running),
    .cur_addr(cur_addr)
  );
endmodule

// File: rtl/rxring_dma_chk.sv
module rxring_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_sel,
  input logic [31:0]   reg_wdata,
  input logic          irq,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          in_ready,
  input logic          running,
  input logic [AW-1:0] cur_addr
);
  logic stat_seen;
  logic ctl_wb;

  assign ctl_wb = mem_ack && mem_we && (mem_addr == cur_addr);

  always_ff @(posedge clk) begin
    if (rst)
      stat_seen <= 1'b0;
    else if (mem_ack && mem_we && (mem_addr == cur_addr + AW'(16)))
      stat_seen <= 1'b1;
    else if (ctl_wb)
      stat_seen <= 1'b0;
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11

  AST_NO_TAKE_DURING_MEM: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !mem_req); // R11

  AST_STAT_FIRST: assert property (@(posedge clk) disable iff (rst)
    ctl_wb |-> stat_seen); // R7

  AST_IRQ_AFTER_CTL: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mem_ack && mem_we && !mem_wdata[31])); // R8

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    irq && !(reg_wr && !reg_sel && reg_wdata[1]) |=> irq); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running |-> !in_ready && !mem_req); // R10
endmodule

bind rxring_dma rxring_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .irq(irq), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .in_ready(in_ready),
  .running(running), .cur_addr(cur_addr)
);

// File: tb/test_rxring_dma.sv
module test_rxring_dma;
  localparam int D0 = 'h100, D1 = 'h120, B0 = 'h400, B1 = 'h600;

  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack, in_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic in_valid = 0, in_last = 0, in_err = 0;
  logic [7:0] in_data = 0;

  logic [31:0] mem [0:1023];
  logic [7:0]  frm [0:127];
  int checks = 0, errors = 0;
  int ord_checks = 0, ord_bad = 0;
  bit stat_seen = 0;

  always #5 clk = ~clk;

  rxring_dma i_rxring_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .in_ready(in_ready)
  );

  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 0;
      mem_rdata <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
          if (mem_addr == D0 + 16 || mem_addr == D1 + 16) stat_seen = 1;
          if (mem_addr == D0 || mem_addr == D1) begin
            ord_checks++;
            if (!stat_seen) ord_bad++;
            stat_seen = 0;
          end
        end
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(int a);
    return mem[a >> 2][8*(a & 3) +: 8];
  endfunction

  function automatic logic [31:0] exp_stat(bit ov, bit er);
    logic [31:0] s = 0;
    s[8] = !ov && !er;
    s[9] = ov;
    s[10] = er;
    return s;
  endfunction

  task automatic arm(int d, int bufa, int nxt, int blen);
    mem[d >> 2] = 32'hE012_0000 | blen;
    mem[(d >> 2) + 1] = nxt;
    mem[(d >> 2) + 2] = bufa;
    mem[(d >> 2) + 4] = 32'hDEAD_BEEF;
    for (int w = 0; w < 128; w++) mem[(bufa >> 2) + w] = 32'hA5A5_A5A5;
  endtask

  task automatic wr_reg(bit sel, logic [31:0] v);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(bit sel, output logic [31:0] v);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic send(int len, bit err);
    for (int i = 0; i < len; i++) begin
      frm[i] = 8'($urandom);
      @(negedge clk);
      in_valid = 1; in_data = frm[i];
      in_last = (i == len - 1); in_err = err && (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_err = 0;
  endtask

  task automatic frame(int d, int bufa, int nxt, int blen, int len, bit err, bit rearm);
    int el, n, bad;
    bit ov;
    logic [31:0] v;
    el = (len > blen) ? blen : len;
    ov = len > blen;
    send(len, err);
    n = 0;
    while (!irq && n < 400) begin @(negedge clk); n++; end
    chk("R8", irq, 1, "irq after frame");
    chk("R6", mem[d >> 2], 32'h6012_0000 | el, "control word writeback");
    chk("R6", mem[(d >> 2) + 4], exp_stat(ov, err), "status word");
    bad = 0;
    for (int j = 0; j < el; j++) if (mb(bufa + j) !== frm[j]) bad++;
    chk("R4", bad, 0, "stored byte mismatches");
    bad = 0;
    for (int j = el; j < el + 12; j++) if (mb(bufa + j) !== 8'hA5) bad++;
    chk("R5", bad, 0, "bytes written past stored length");
    repeat (3) @(negedge clk);
    chk("R8", irq, 1, "irq held");
    wr_reg(0, 32'h2);
    chk("R8", irq, 0, "irq cleared by write-one");
    rd_reg(1, v);
    chk("R9", v, nxt, "current address follows next pointer");
    if (rearm) arm(d, bufa, nxt, 64);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int ci, bad;
    void'($urandom(32'd20240611));
    for (int w = 0; w < 1024; w++) mem[w] = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", in_ready, 0, "in_ready after reset");
    chk("R1", mem_req, 0, "mem_req after reset");
    chk("R1", irq, 0, "irq after reset");
    rd_reg(0, v); chk("R1", v, 0, "control register after reset");
    rd_reg(1, v); chk("R1", v, 0, "current address after reset");

    arm(D0, B0, D1, 64);
    arm(D1, B1, D0, 64);
    wr_reg(1, D0);
    wr_reg(0, 32'h10);
    rd_reg(0, v); chk("R2", v, 32'h10, "running after start");

    ci = 0;
    for (int f = 0; f < 8; f++) begin
      if (ci == 0) frame(D0, B0, D1, 64, 1 + ($urandom % 64), ($urandom % 4) == 0, 1);
      else         frame(D1, B1, D0, 64, 1 + ($urandom % 64), ($urandom % 4) == 0, 1);
      ci ^= 1;
    end

    frame(D0, B0, D1, 64, 64, 0, 1);  // R5 exact length, no overflow
    frame(D1, B1, D0, 64, 75, 0, 1);  // R5 overflow
    frame(D0, B0, D1, 64, 17, 1, 0);  // R6 source error, D0 left unowned
    frame(D1, B1, D0, 64, 30, 0, 1);

    // R3: engine now polls D0 whose ownership bit is 0
    @(negedge clk);
    in_valid = 1; in_data = 8'h3C;
    bad = 0;
    repeat (40) begin @(negedge clk); if (in_ready) bad++; end
    in_valid = 0;
    chk("R3", bad, 0, "cycles ready on unowned descriptor");
    chk("R3", mem[D0 >> 2][31], 0, "unowned descriptor untouched");
    wr_reg(1, 32'h300);
    rd_reg(1, v); chk("R2", v, D0, "current address write ignored while running");
    arm(D0, B0, D1, 64);
    frame(D0, B0, D1, 64, 23, 0, 0);  // R3 resumes once owned

    // R10: stop mid-descriptor, frame on D1 still completes
    wr_reg(0, 32'h20);
    rd_reg(0, v); chk("R10", v, 32'h10, "still running until boundary");
    frame(D1, B1, D0, 64, 9, 0, 0);
    rd_reg(0, v); chk("R10", v, 0, "stopped after boundary");
    repeat (10) @(negedge clk);
    chk("R10", in_ready, 0, "no ready when stopped");
    chk("R10", mem_req, 0, "no memory request when stopped");

    // R5: short buffer of 10 bytes, partial trailing word
    arm(D0, B0, D1, 10);
    wr_reg(0, 32'h10);
    frame(D0, B0, D1, 10, 13, 0, 0);
    chk("R5", mb(B0 + 10), 8'hA5, "byte 10 untouched");
    chk("R5", mb(B0 + 11), 8'hA5, "byte 11 untouched");

    chk("R7", ord_bad, 0, "control writes before status");
    chk("R7", (ord_checks > 10) ? 1 : 0, 1, "control writes observed");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule